// File: doc/BRIEF.md
# Infrared SIR Pulse Stretcher

This block turns the short low-going pulses that an infrared receiver produces for each zero bit into the full-width low levels a standard UART receiver expects. It runs from a clock at sixteen times the bit rate. The optical input is brought into that clock domain by a chain of flip-flops. A falling edge found there starts a countdown of one bit period, and the serial output is held low for as long as that countdown runs.

The line is a raw level stream with no framing of its own, so there is no valid/ready handshake and no back-pressure: the output level is meaningful on every clock cycle, and the UART downstream samples it at its own pace. An active-low reset clears the decoder. While it is held low, reception is disabled and the output stays at the idle level.

Top module: `sir_pulse_decoder`

## Requirements
- R1: While `rst_n` is low, `rx_o` is 1 (idle). After reset with no pulse seen, `rx_o` stays 1.
- R2: When `ir_rx_i` is first sampled low by rising edge n after being high, `rx_o` goes to 0 after rising edge n+SYNC_STAGES (edge n+2 with the default of two synchronizer stages).
- R3: A single pulse holds `rx_o` at 0 for exactly BIT_LEN (default 16) clock cycles. `rx_o` returns to 1 on the following cycle.
- R4: A falling edge of `ir_rx_i` that arrives during the low window reloads the full BIT_LEN count. Back-to-back zero bits therefore give an unbroken low level that ends BIT_LEN cycles after the last reload, and this holds even when the reload lands on the final cycle of the window.
- R5: `ir_rx_i` held low for longer than a bit period produces only one window of BIT_LEN cycles. Only a fresh high-to-low transition retriggers the stretch.
- R6: Asserting `rst_n` low in the middle of a stretch drives `rx_o` to 1 at once and discards the rest of the window.
- R7: Pulses on `ir_rx_i` while `rst_n` is low are ignored. No low window appears on `rx_o` after release as a result of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_16x | input | 1 | Clock at 16x the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset, also the receive disable |
| ir_rx_i | input | 1 | Asynchronous pulse input from the optical receiver, low = pulse |
| rx_o | output | 1 | Stretched serial data towards the UART, idle high |

## Verification
The hardest case to reach from the ports is a second falling edge that reloads the counter on the last cycle of a window. If the timing is off by one cycle, the output either shows a one-cycle high glitch or merges correctly, and only exact placement separates the two. The stimulus places each falling edge a counted number of cycles after the previous one, so the reload lands on the final low cycle. Mid-window reset and pulses during reset are driven the same way. The scoreboard predicts every cycle of `rx_o` from the queued windows.

// File: rtl/sir_dec_pkg.sv
package sir_dec_pkg;
  parameter int unsigned SIR_BIT_LEN     = 16;
  parameter int unsigned SIR_SYNC_STAGES = 2;
endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sir_fall_detect.sv
module sir_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;

  // R5: one transition gives one strobe, never two in a row
  p_single_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sir_stretch_timer.sv
module sir_stretch_timer #(
  parameter int unsigned BIT_LEN = 16,
  localparam int unsigned CNT_W  = $clog2(BIT_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BIT_LEN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (fall_i)      cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  // R4: every detected edge reloads the full bit length
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_i |=> cnt == LOAD);

  // R3: without a new edge the window shrinks by one each cycle
  p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fall_i) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/sir_pulse_decoder.sv
module sir_pulse_decoder
  import sir_dec_pkg::*;
#(
  parameter int unsigned BIT_LEN     = SIR_BIT_LEN,
  parameter int unsigned SYNC_STAGES = SIR_SYNC_STAGES
) (
  input  logic clk_16x,
  input  logic rst_n,
  input  logic ir_rx_i,
  output logic rx_o
);
  logic ir_sync;
  logic ir_fall;
  logic stretching;

  sir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_16x),
    .rst_n (rst_n),
    .d_i   (ir_rx_i),
    .q_o   (ir_sync)
  );

  sir_fall_detect u_fall (
    .clk    (clk_16x),
    .rst_n  (rst_n),
    .lvl_i  (ir_sync),
    .fall_o (ir_fall)
  );

  sir_stretch_timer #(.BIT_LEN(BIT_LEN)) u_timer (
    .clk    (clk_16x),
    .rst_n  (rst_n),
    .fall_i (ir_fall),
    .busy_o (stretching)
  );

  assign rx_o = ~stretching;

  // R2: the output only starts a low window after a detected edge
  p_fall_cause_r2: assert property (@(posedge clk_16x) disable iff (!rst_n)
    $fell(rx_o) |-> $past(ir_fall));

  // R3: the output returns high only when no edge arrived
  p_release_r3: assert property (@(posedge clk_16x) disable iff (!rst_n)
    $rose(rx_o) |-> !$past(ir_fall));
endmodule

// File: tb/sim_sir_pulse_decoder.sv
module sim_sir_pulse_decoder;
  localparam int BITL = 16;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  typedef struct { int first; int last; } win_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir = 1'b1;
  logic rx;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  string tag = "R1";
  win_t q[$];

  sir_pulse_decoder #(.BIT_LEN(BITL), .SYNC_STAGES(SYNC)) u0 (
    .clk_16x (clk),
    .rst_n   (rst_n),
    .ir_rx_i (ir),
    .rx_o    (rx)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: rx_o=%b expected %b", req, cyc, act, exp);
    end
  endtask

  // monitor: pop the expected windows and compare every cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0 && q[0].last < cyc) void'(q.pop_front());
      if (!rst_n) check(tag, rx, 1'b1);
      else check(tag, rx, (q.size() > 0 && q[0].first <= cyc) ? 1'b0 : 1'b1);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pulse of w cycles, pushes the window it must cause
  task automatic pulse(input int w);
    @(negedge clk);
    ir = 1'b0;
    q.push_back('{cyc + LAT, cyc + LAT + BITL - 1});
    repeat (w) @(negedge clk);
    ir = 1'b1;
  endtask

  task automatic raw_pulse(input int w);
    @(negedge clk);
    ir = 1'b0;
    repeat (w) @(negedge clk);
    ir = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tag = "R1";
    idle(5);
    @(negedge clk) rst_n = 1'b1;
    idle(10);

    tag = "R2_R3";              // single 3/16 pulses, isolated
    pulse(3); idle(25);
    pulse(1); idle(25);

    tag = "R4";                 // restart inside the window
    pulse(3); idle(4);          // next edge 8 cycles later
    pulse(3); idle(30);
    pulse(3); idle(11);         // next edge lands on last low cycle
    pulse(3); idle(30);
    pulse(2); idle(2); pulse(2); idle(2); pulse(2); idle(30);

    tag = "R5";                 // long low level, single window
    pulse(40); idle(25);

    tag = "R6";                 // reset in the middle of a stretch
    pulse(3); idle(4);
    @(negedge clk) begin rst_n = 1'b0; q.delete(); end
    idle(6);

    tag = "R7";                 // pulses ignored while held in reset
    raw_pulse(3); idle(3); raw_pulse(5); idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(30);

    tag = "R3";                 // normal function after release
    pulse(3); idle(25);

    check("R1", rx, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule